// File: doc/BRIEF.md
# Multiprocessor Boot and System Control Registers

This block is the system control register file of a bus controller in a multiprocessor system. Software reads from it how much RAM is installed and which processors exist, and each processor can learn its own hardware number by reading an identity register that answers differently depending on which processor asked. Secondary processors are held stopped after reset. Only the boot processor runs.

Bring-up software first fills a small startup mailbox RAM that belongs to each secondary processor. It writes the entry address into word 0 and the software processor number into word 1. It then writes a processor mask to the run-enable register, which releases every present processor named in the mask. A write of zero to the power register arms a shutdown countdown. When the countdown ends, the power-off output rises and stays high.

The register bus carries 32-bit words. A request is presented for one cycle with a requester processor id. Read data appears on the cycle after the request.

Top module: `mpboot_sysctl`

## Requirements
- R1: A read at byte offset 0x200 returns the `ramSize` input, presented on `rspRdata` in the cycle after the request.
- R2: A read at offset 0x210 returns `cpuPresent` in bits NCPU-1..0 (bit i is hardware processor i), with all upper bits zero.
- R3: A read at offset 0x218 returns a mask with only bit `reqCpu` set. If `reqCpu` is NCPU or larger, the read returns zero.
- R4: After reset, `cpuRun` has only bit BOOT_CPU set, `powerOff` is 0 and `rspRdata` is 0.
- R5: A write at offset 0x214 sets `cpuRun` to the written mask from the next cycle on. A read at 0x214 returns the current `cpuRun`. No other access changes `cpuRun`.
- R6: Written enable bits for processors absent from `cpuPresent` are dropped, both on `cpuRun` and in the 0x214 read-back.
- R7: Processor i owns a region at 0x8000 + i*0x400. Its mailbox word w (w < 64) sits at region offset 0x300 + 4*w. Any requester can read and write any mailbox word, and each word keeps its value independently of every other word.
- R8: A write of zero at offset 0x208 raises `powerOff` on exactly the POWER_DELAY-th rising edge after the write edge. Once high, `powerOff` stays high until reset.
- R9: A nonzero write at 0x208 has no effect. A further zero write while the countdown runs does not restart it. Reads at 0x208 return zero.
- R10: Reads at unmapped offsets return zero, and writes to them change neither `cpuRun`, nor any mailbox word, nor `powerOff`.
- R11: `rspRdata` is zero in the cycle after any cycle that has no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Register request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the register |
| reqWdata | input | 32 | Write data |
| reqCpu | input | CPU_ID_W | Hardware number of the requesting processor |
| ramSize | input | 32 | Installed RAM size, reported as is |
| cpuPresent | input | NCPU | Processors fitted in the system |
| rspRdata | output | 32 | Read data, one cycle after the request |
| cpuRun | output | NCPU | Per-processor run enable |
| powerOff | output | 1 | System power-off request, sticky |

## Verification
The identity register is swept over every requester id up to twice NCPU. This separates correct one-hot answers from a shared value, and it shows whether out-of-range ids read as zero.

The run-enable register is driven with every write mask against several presence patterns. Comparing `cpuRun` and its read-back against the bitwise AND tells apart a design that drops absent bits from one that stores the raw mask.

Every mailbox word of every processor is loaded with a value that encodes both indices and is then read back. This exposes address aliasing between words or between processors.

The power countdown is checked edge by edge around the expected edge. It is also checked with a nonzero write and with a zero write repeated during the countdown, which separates a correct countdown from one that is off by one, fires on any write, or restarts.

// File: rtl/mpboot_sysctl_pkg.sv
package mpboot_sysctl_pkg;

  // Byte offsets of the global control registers
  localparam int unsigned REG_RAM_SIZE = 32'h200;
  localparam int unsigned REG_POWER    = 32'h208;
  localparam int unsigned REG_PRESENT  = 32'h210;
  localparam int unsigned REG_ENABLE   = 32'h214;
  localparam int unsigned REG_SELF     = 32'h218;

  // Per-processor region layout
  localparam int unsigned CPU_REGION_BASE  = 32'h8000;
  localparam int unsigned CPU_REGION_SHIFT = 10;
  localparam int unsigned MBOX_OFFSET      = 32'h300;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAM,
    SEL_PRESENT,
    SEL_ENABLE,
    SEL_SELF,
    SEL_MBOX
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrPowerZero;
    logic   wrMbox;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/mpboot_sysctl_ctrl.sv
module mpboot_sysctl_ctrl
  import mpboot_sysctl_pkg::*;
#(
  parameter int unsigned NCPU       = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MBOX_WORDS = 64,
  localparam int unsigned CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int unsigned WORD_W    = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  output ctlStrobe_t           stb,
  output logic [CPU_IDX_W-1:0] mboxCpu,
  output logic [WORD_W-1:0]    mboxWord
);

  localparam int unsigned REGION_SPAN = 32'd1 << CPU_REGION_SHIFT;
  localparam int unsigned REGION_END  = CPU_REGION_BASE + NCPU * REGION_SPAN;
  localparam int unsigned MBOX_END    = MBOX_OFFSET + 4 * MBOX_WORDS;

  logic [31:0] addrExt;
  logic [31:0] relAddr;
  logic [31:0] inRegion;
  logic [31:0] mboxRel;
  logic        regionHit;
  logic        mboxHit;
  logic        isRead;
  logic        isWrite;

  assign addrExt   = 32'(reqAddr);
  assign relAddr   = addrExt - CPU_REGION_BASE;
  assign inRegion  = relAddr & (REGION_SPAN - 1);
  assign mboxRel   = inRegion - MBOX_OFFSET;
  assign regionHit = (addrExt >= CPU_REGION_BASE) && (addrExt < REGION_END);
  assign mboxHit   = regionHit && (inRegion >= MBOX_OFFSET) && (inRegion < MBOX_END);
  assign isRead    = reqValid && !reqWrite;
  assign isWrite   = reqValid && reqWrite;

  assign mboxCpu  = CPU_IDX_W'(relAddr >> CPU_REGION_SHIFT);
  assign mboxWord = WORD_W'(mboxRel >> 2);

  always_comb begin
    stb             = '0;
    stb.rdSel       = SEL_NONE;
    stb.wrEnable    = isWrite && (addrExt == REG_ENABLE);
    stb.wrPowerZero = isWrite && (addrExt == REG_POWER) && (reqWdata == 32'd0);
    stb.wrMbox      = isWrite && mboxHit;
    if (isRead) begin
      if (mboxHit)                         stb.rdSel = SEL_MBOX;
      else if (addrExt == REG_RAM_SIZE)    stb.rdSel = SEL_RAM;
      else if (addrExt == REG_PRESENT)     stb.rdSel = SEL_PRESENT;
      else if (addrExt == REG_ENABLE)      stb.rdSel = SEL_ENABLE;
      else if (addrExt == REG_SELF)        stb.rdSel = SEL_SELF;
      else                                 stb.rdSel = SEL_NONE;
    end
  end

endmodule

// File: rtl/mpboot_sysctl_dp.sv
module mpboot_sysctl_dp
  import mpboot_sysctl_pkg::*;
#(
  parameter int unsigned NCPU        = 4,
  parameter int unsigned CPU_ID_W    = 5,
  parameter int unsigned MBOX_WORDS  = 64,
  parameter int unsigned BOOT_CPU    = 0,
  parameter int unsigned POWER_DELAY = 1000,
  localparam int unsigned CPU_IDX_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int unsigned WORD_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1,
  localparam int unsigned CNT_W      = $clog2(POWER_DELAY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [CPU_IDX_W-1:0] mboxCpu,
  input  logic [WORD_W-1:0]    mboxWord,
  input  logic [31:0]          reqWdata,
  input  logic [CPU_ID_W-1:0]  reqCpu,
  input  logic [31:0]          ramSize,
  input  logic [NCPU-1:0]      cpuPresent,
  output logic [31:0]          rspRdata,
  output logic [NCPU-1:0]      cpuRun,
  output logic                 powerOff
);

  logic [31:0]      mboxRd [NCPU];
  logic [31:0]      selfMask;
  logic [31:0]      rdNext;
  logic             powerArmed;
  logic [CNT_W-1:0] powerCnt;

  // One mailbox RAM per processor
  for (genvar c = 0; c < NCPU; c++) begin : g_mbox
    logic [31:0] mem [MBOX_WORDS];
    always_ff @(posedge clk) begin
      if (stb.wrMbox && (mboxCpu == CPU_IDX_W'(c))) begin
        mem[mboxWord] <= reqWdata;
      end
    end
    assign mboxRd[c] = mem[mboxWord];
  end

  // Identity answer depends on the requester
  always_comb begin
    selfMask = '0;
    if (32'(reqCpu) < NCPU) begin
      selfMask = 32'd1 << reqCpu;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_RAM:     rdNext = ramSize;
      SEL_PRESENT: rdNext = 32'(cpuPresent);
      SEL_ENABLE:  rdNext = 32'(cpuRun);
      SEL_SELF:    rdNext = selfMask;
      SEL_MBOX:    rdNext = mboxRd[mboxCpu];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspRdata <= '0;
    else       rspRdata <= rdNext;
  end

  // Run enables: boot processor only at reset, absent processors masked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRun <= NCPU'(1) << BOOT_CPU;
    end else if (stb.wrEnable) begin
      cpuRun <= reqWdata[NCPU-1:0] & cpuPresent;
    end
  end

  // Shutdown countdown, armed once, sticky result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerArmed <= 1'b0;
      powerCnt   <= '0;
      powerOff   <= 1'b0;
    end else if (!powerArmed) begin
      if (stb.wrPowerZero) begin
        powerArmed <= 1'b1;
        powerCnt   <= CNT_W'(POWER_DELAY - 1);
      end
    end else if (!powerOff) begin
      if (powerCnt == '0) powerOff <= 1'b1;
      else                powerCnt <= powerCnt - 1'b1;
    end
  end

endmodule

// File: rtl/mpboot_sysctl.sv
module mpboot_sysctl
  import mpboot_sysctl_pkg::*;
#(
  parameter int unsigned NCPU        = 4,
  parameter int unsigned CPU_ID_W    = 5,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned MBOX_WORDS  = 64,
  parameter int unsigned BOOT_CPU    = 0,
  parameter int unsigned POWER_DELAY = 1000,
  localparam int unsigned CPU_IDX_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int unsigned WORD_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [31:0]         reqWdata,
  input  logic [CPU_ID_W-1:0] reqCpu,
  input  logic [31:0]         ramSize,
  input  logic [NCPU-1:0]     cpuPresent,
  output logic [31:0]         rspRdata,
  output logic [NCPU-1:0]     cpuRun,
  output logic                powerOff
);

  ctlStrobe_t           stb;
  logic [CPU_IDX_W-1:0] mboxCpu;
  logic [WORD_W-1:0]    mboxWord;

  mpboot_sysctl_ctrl #(
    .NCPU(NCPU), .ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .stb(stb), .mboxCpu(mboxCpu), .mboxWord(mboxWord)
  );

  mpboot_sysctl_dp #(
    .NCPU(NCPU), .CPU_ID_W(CPU_ID_W), .MBOX_WORDS(MBOX_WORDS),
    .BOOT_CPU(BOOT_CPU), .POWER_DELAY(POWER_DELAY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mboxCpu(mboxCpu), .mboxWord(mboxWord),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .ramSize(ramSize),
    .cpuPresent(cpuPresent), .rspRdata(rspRdata), .cpuRun(cpuRun),
    .powerOff(powerOff)
  );

endmodule

// File: rtl/mpboot_sysctl_chk.sv
module mpboot_sysctl_chk
  import mpboot_sysctl_pkg::*;
#(
  parameter int unsigned NCPU     = 4,
  parameter int unsigned CPU_ID_W = 5,
  parameter int unsigned ADDR_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [31:0]         reqWdata,
  input logic [CPU_ID_W-1:0] reqCpu,
  input logic [31:0]         ramSize,
  input logic [NCPU-1:0]     cpuPresent,
  input logic [31:0]         rspRdata,
  input logic [NCPU-1:0]     cpuRun,
  input logic                powerOff
);

  logic enaWrite;
  logic ramRead;
  logic selfRead;
  assign enaWrite = reqValid && reqWrite && (32'(reqAddr) == REG_ENABLE);
  assign ramRead  = reqValid && !reqWrite && (32'(reqAddr) == REG_RAM_SIZE);
  assign selfRead = reqValid && !reqWrite && (32'(reqAddr) == REG_SELF);

  // R1
  ram_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramRead |=> rspRdata == $past(ramSize));

  // R3
  self_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    selfRead |=> $onehot0(rspRdata));

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enaWrite |=> $stable(cpuRun));

  // R6
  run_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    enaWrite |=> cpuRun == ($past(reqWdata[NCPU-1:0]) & $past(cpuPresent)));

  // R8
  power_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerOff |=> powerOff);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqWrite) |=> rspRdata == 32'd0);

endmodule

bind mpboot_sysctl mpboot_sysctl_chk #(
  .NCPU(NCPU), .CPU_ID_W(CPU_ID_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mpboot_sysctl_bench.sv
module mpboot_sysctl_bench;

  localparam int unsigned NCPU   = 4;
  localparam int unsigned IDW    = 5;
  localparam int unsigned AW     = 16;
  localparam int unsigned WORDS  = 64;
  localparam int unsigned DELAY  = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqWrite = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [31:0]     reqWdata = '0;
  logic [IDW-1:0]  reqCpu = '0;
  logic [31:0]     ramSize = 32'h0400_0000;
  logic [NCPU-1:0] cpuPresent = 4'hF;
  logic [31:0]     rspRdata;
  logic [NCPU-1:0] cpuRun;
  logic            powerOff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mpboot_sysctl #(
    .NCPU(NCPU), .CPU_ID_W(IDW), .ADDR_W(AW), .MBOX_WORDS(WORDS),
    .BOOT_CPU(0), .POWER_DELAY(DELAY)
  ) u_mpboot_sysctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCpu(reqCpu),
    .ramSize(ramSize), .cpuPresent(cpuPresent), .rspRdata(rspRdata),
    .cpuRun(cpuRun), .powerOff(powerOff)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doWrite(input int unsigned addr, input logic [31:0] data);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(addr); reqWdata = data;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input int unsigned addr, input int unsigned cpu, output logic [31:0] data);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(addr); reqCpu = IDW'(cpu);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    data = rspRdata;
  endtask

  function automatic int unsigned mboxAddr(input int unsigned c, input int unsigned w);
    return 32'h8000 + c * 32'h400 + 32'h300 + 4 * w;
  endfunction

  function automatic logic [31:0] mboxVal(input int unsigned c, input int unsigned w);
    return 32'hA500_0000 ^ (c << 16) ^ (w * 32'h0101) ^ 32'h3C;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    doReset();

    // R4 reset state
    check("R4 run", 32'(cpuRun), 32'h1);
    check("R4 power", 32'(powerOff), 32'h0);
    check("R4 rdata", rspRdata, 32'h0);

    // R1 RAM size for a few straps
    for (int k = 0; k < 4; k++) begin
      ramSize = 32'h0010_0000 << (k * 3);
      doRead(32'h200, k, rd);
      check("R1 ram size", rd, 32'h0010_0000 << (k * 3));
    end

    // R11 idle cycle returns zero
    @(negedge clk);
    check("R11 idle", rspRdata, 32'h0);

    // R2 presence sweep
    for (int p = 1; p < 16; p++) begin
      cpuPresent = 4'(p);
      doRead(32'h210, 0, rd);
      check("R2 present", rd, 32'(p));
    end
    cpuPresent = 4'hF;

    // R3 identity per requester, including ids beyond NCPU
    for (int c = 0; c < 8; c++) begin
      doRead(32'h218, c, rd);
      check("R3 self", rd, (c < NCPU) ? (32'd1 << c) : 32'd0);
    end

    // R5 and R6: every mask against several presence patterns
    for (int p = 0; p < 4; p++) begin
      cpuPresent = (p == 0) ? 4'hF : (p == 1) ? 4'h5 : (p == 2) ? 4'hB : 4'h1;
      for (int m = 0; m < 16; m++) begin
        doWrite(32'h214, 32'hFFFF_FFF0 | 32'(m));
        check("R6 run masked", 32'(cpuRun), 32'(4'(m) & cpuPresent));
        doRead(32'h214, 0, rd);
        check("R5 enable readback", rd, 32'(4'(m) & cpuPresent));
      end
    end
    cpuPresent = 4'hF;
    doWrite(32'h214, 32'h6);

    // R7 fill every mailbox word then read it back from another requester
    for (int c = 0; c < NCPU; c++)
      for (int w = 0; w < WORDS; w++)
        doWrite(mboxAddr(c, w), mboxVal(c, w));
    for (int c = 0; c < NCPU; c++)
      for (int w = 0; w < WORDS; w++) begin
        doRead(mboxAddr(c, w), (c + 1) % NCPU, rd);
        check("R7 mailbox", rd, mboxVal(c, w));
      end

    // R10 unmapped reads and writes
    begin
      int unsigned holes [6] = '{32'h0, 32'h204, 32'h20C, 32'h8000, 32'h82FC, 32'h9300};
      for (int h = 0; h < 6; h++) begin
        doWrite(holes[h], 32'hDEAD_BEEF);
        doRead(holes[h], 1, rd);
        check("R10 unmapped read", rd, 32'h0);
      end
    end
    check("R10 run untouched", 32'(cpuRun), 32'h6);
    doRead(mboxAddr(0, 0), 0, rd);
    check("R10 mailbox untouched", rd, mboxVal(0, 0));
    doRead(mboxAddr(1, 63), 0, rd);
    check("R10 mailbox untouched", rd, mboxVal(1, 63));
    check("R10 power untouched", 32'(powerOff), 32'h0);

    // R9 nonzero power write ignored, read returns zero
    doWrite(32'h208, 32'h1);
    repeat (3 * DELAY) @(negedge clk);
    check("R9 nonzero ignored", 32'(powerOff), 32'h0);
    doRead(32'h208, 0, rd);
    check("R9 power read", rd, 32'h0);

    // R8 exact countdown, then sticky
    doWrite(32'h208, 32'h0);
    for (int k = 1; k <= DELAY; k++) begin
      @(negedge clk);
      check("R8 countdown", 32'(powerOff), (k >= DELAY) ? 32'h1 : 32'h0);
    end
    repeat (10) @(negedge clk);
    check("R8 sticky", 32'(powerOff), 32'h1);

    // R9 repeated zero write does not restart the countdown
    doReset();
    check("R4 run after reset", 32'(cpuRun), 32'h1);
    check("R4 power after reset", 32'(powerOff), 32'h0);
    doWrite(32'h208, 32'h0);
    @(negedge clk);
    doWrite(32'h208, 32'h0);
    for (int k = 3; k <= DELAY; k++) begin
      @(negedge clk);
      check("R9 no restart", 32'(powerOff), (k >= DELAY) ? 32'h1 : 32'h0);
    end

    finishRun();
  end

endmodule